// File: doc/BRIEF.md
# SPI Word Master with Register File

This block is a memory-mapped SPI master. Software configures it through a small set of 32-bit registers, loads words into a four-deep transmit queue and collects received words from a four-deep receive queue. A single start command moves between 1 and 32 bits. Bits leave most significant first from a right-aligned word, and the bits sampled on the input pin are packed right-aligned into the word that enters the receive queue.

The engine supports both clock phases. The idle clock level can be driven or only weakly held, high or low. Chip select comes from one of four lines, with a selectable polarity. It is either held by software or asserted by the engine for the duration of a transfer. A programmable divider sets the serial clock half-period. Sticky event flags report transfer completion and queue misuse, and software clears them by writing ones.

Top module: `spi_word_master`

## Requirements
- R1: After reset the status register (offset 0x08) reads 0x00A00000 (receive empty at bit 23, transmit empty at bit 21, all else 0), every chip select line is high, the serial clock is low and is driven, not weak.
- R2: A write to the command register (0x00) with bits 31 (enable), 30 (start) and 28 (master) all set, while idle, starts a transfer. Busy (status bit 31) then reads 1 for exactly 2*N*(D+1)+1 cycles after the write edge, with N bits and divisor D. On the edge where busy clears, ready (status bit 30) sets.
- R3: Command bits 4:0 hold the bit count minus one. The low N bits of the transmit word go out MSB-first. The N sampled bits are pushed right-aligned (the last sampled bit is bit 0).
- R4: Command bit 21 = 0 samples on the leading clock edge and shifts on the trailing edge. Bit 21 = 1 shifts on the leading edge and samples on the trailing edge. In both modes a looped-back transfer returns the sent bits.
- R5: Command bit 24 sets the idle clock level. Command bit 25 = 1 makes the idle clock weak (sclkWeak = 1); otherwise the idle clock is driven.
- R6: Chip select uses command2 bits 19:18 as line select and command bit 13 as polarity (0 = active low). With command bit 11 set, the active state follows command bit 12. With bit 11 clear, the selected line is active only while busy. Unselected lines sit at the inactive level.
- R7: Status bits 30, 25, 24, 19 and 18 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: The transmit queue (written at 0x100) holds 4 words. A push while it is full is dropped and sets status bit 19. Status bit 20 reads 1 when the queue is full.
- R9: The receive queue (read at 0x180) holds 4 words, and status bit 22 reads 1 when it is full. A completed receive into a full queue is dropped and sets bit 25. A read while the queue is empty returns 0 and sets bit 18.
- R10: A start with transmit enabled (command2 bit 30) and an empty transmit queue sets status bit 24 and shifts out zeros.
- R11: With command2 bit 31 clear, nothing is pushed to the receive queue. With command2 bit 30 clear, the transmit queue is not popped and zeros are shifted out.
- R12: A start command is ignored unless bits 31 and 28 are set in the same write and the engine is idle.
- R13: Status2 (0x1C) reports the transmit queue level in bits 2:0 and the receive queue level in bits 18:16.
- R14: Command2 bits 7:0 set the divisor D. Each serial clock half-period lasts D+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (pops the receive queue at 0x180) |
| busAddr | input | 9 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| sclk | output | 1 | Serial clock |
| sclkWeak | output | 1 | 1 when the idle clock is only weakly held |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Chip select lines |

## Verification
The bench loops the output pin back to the input for several lengths (8, 12 and 32 bits) and both clock phases. A bit-order or alignment error changes the returned word, and a phase error shifts it by one bit. A forced-high input on a 5-bit transfer with zero data separates the receive path from the transmit path and shows right alignment. Busy is counted cycle by cycle at divisors 0 and 2 to pin down the divider and the completion edge. Queue fill, drain, empty reads and empty starts exercise every sticky flag.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  localparam logic [8:0] OFF_CMD   = 9'h000;
  localparam logic [8:0] OFF_CMD2  = 9'h004;
  localparam logic [8:0] OFF_STAT  = 9'h008;
  localparam logic [8:0] OFF_STAT2 = 9'h01C;
  localparam logic [8:0] OFF_TXQ   = 9'h100;
  localparam logic [8:0] OFF_RXQ   = 9'h180;

  localparam logic [31:0] CMD_MASK  = 32'h9320_381F;
  localparam logic [31:0] CMD2_MASK = 32'hC00C_00FF;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} xferState_t;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic loadShift;
    logic takeTx;
    logic shiftOut;
    logic sampleIn;
    logic pushRx;
  } dpStrobe_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdata  = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> $stable(count));
endmodule

// File: rtl/spi_word_dp.sv
module spi_word_dp
  import spi_word_pkg::*;
#(
  parameter int QDEPTH = 4,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [31:0]      busWdata,
  input  logic             miso,
  output logic             mosi,
  output logic [31:0]      rxHead,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic             txEmpty,
  output logic             txFull,
  output logic             rxEmpty,
  output logic             rxFull
);
  logic [31:0] txHead, shiftReg, rxShift, txWord;

  spi_word_fifo #(.DEPTH(QDEPTH), .WIDTH(32)) u_txq (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .pop(stb.takeTx),
    .wdata(busWdata), .rdata(txHead), .count(txCount),
    .empty(txEmpty), .full(txFull));

  spi_word_fifo #(.DEPTH(QDEPTH), .WIDTH(32)) u_rxq (
    .clk(clk), .rstN(rstN), .push(stb.pushRx), .pop(stb.rxPop),
    .wdata(rxShift), .rdata(rxHead), .count(rxCount),
    .empty(rxEmpty), .full(rxFull));

  assign txWord = stb.takeTx ? txHead : 32'h0;
  assign mosi   = shiftReg[31];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxShift  <= '0;
    end else if (stb.loadShift) begin
      shiftReg <= txWord << (5'd31 - busWdata[4:0]);
      rxShift  <= '0;
    end else begin
      if (stb.shiftOut) shiftReg <= {shiftReg[30:0], 1'b0};
      if (stb.sampleIn) rxShift  <= {rxShift[30:0], miso};
    end
  end

  assert_load_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadShift |-> !stb.shiftOut && !stb.sampleIn && !stb.pushRx);
endmodule

// File: rtl/spi_word_ctrl.sv
module spi_word_ctrl
  import spi_word_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int DIV_W  = 8,
  localparam int CNT_W  = $clog2(QDEPTH + 1),
  localparam int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [8:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [31:0]       rxHead,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              txEmpty,
  input  logic              txFull,
  input  logic              rxEmpty,
  input  logic              rxFull,
  output dpStrobe_t         stb,
  output logic              sclk,
  output logic              sclkWeak,
  output logic [NUM_CS-1:0] csN
);
  xferState_t state;
  logic [31:0] cmdReg, cmd2Reg;
  logic readyF, rxOvfF, txUnrF, txOvfF, rxUnrF;
  logic [DIV_W-1:0] halfCnt;
  logic [6:0] edgeIdx, lastIdx;
  logic [5:0] nBits;
  logic [4:0] xferLen;
  logic xferCpha, sclkTog, busy, tick, lead, lastEdge;
  logic wrCmd, wrCmd2, wrStat, rdRxq, goReq, txEn, rxEn, csActive, csPol;

  assign wrCmd  = busWr && busAddr == OFF_CMD;
  assign wrCmd2 = busWr && busAddr == OFF_CMD2;
  assign wrStat = busWr && busAddr == OFF_STAT;
  assign rdRxq  = busRd && busAddr == OFF_RXQ;
  assign txEn   = cmd2Reg[30];
  assign rxEn   = cmd2Reg[31];
  assign busy   = state != ST_IDLE;
  assign goReq  = wrCmd && busWdata[31] && busWdata[30] && busWdata[28] && !busy;

  assign nBits    = {1'b0, xferLen} + 6'd1;
  assign lastIdx  = {nBits, 1'b0} - 7'd1;
  assign tick     = state == ST_XFER && halfCnt == cmd2Reg[DIV_W-1:0];
  assign lead     = !edgeIdx[0];
  assign lastEdge = edgeIdx == lastIdx;

  always_comb begin
    stb           = '0;
    stb.txPush    = busWr && busAddr == OFF_TXQ;
    stb.rxPop     = rdRxq && !rxEmpty;
    stb.loadShift = goReq;
    stb.takeTx    = goReq && txEn && !txEmpty;
    stb.sampleIn  = tick && (xferCpha ? !lead : lead);
    stb.shiftOut  = tick && !lastEdge &&
                    (xferCpha ? (lead && edgeIdx != 7'd0) : !lead);
    stb.pushRx    = state == ST_DONE && rxEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      halfCnt  <= '0;
      edgeIdx  <= '0;
      sclkTog  <= 1'b0;
      xferLen  <= '0;
      xferCpha <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (goReq) begin
          state    <= ST_XFER;
          halfCnt  <= '0;
          edgeIdx  <= '0;
          sclkTog  <= 1'b0;
          xferLen  <= busWdata[4:0];
          xferCpha <= busWdata[21];
        end
        ST_XFER: begin
          halfCnt <= tick ? '0 : halfCnt + 1'b1;
          if (tick) begin
            sclkTog <= !sclkTog;
            edgeIdx <= edgeIdx + 7'd1;
            if (lastEdge) state <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      cmd2Reg <= '0;
      readyF  <= 1'b0;
      rxOvfF  <= 1'b0;
      txUnrF  <= 1'b0;
      txOvfF  <= 1'b0;
      rxUnrF  <= 1'b0;
    end else begin
      if (wrCmd)  cmdReg  <= busWdata & CMD_MASK & ~32'h4000_0000;
      if (wrCmd2) cmd2Reg <= busWdata & CMD2_MASK;
      readyF <= (readyF && !(wrStat && busWdata[30])) || state == ST_DONE;
      rxOvfF <= (rxOvfF && !(wrStat && busWdata[25])) ||
                (state == ST_DONE && rxEn && rxFull);
      txUnrF <= (txUnrF && !(wrStat && busWdata[24])) ||
                (goReq && txEn && txEmpty);
      txOvfF <= (txOvfF && !(wrStat && busWdata[19])) || (stb.txPush && txFull);
      rxUnrF <= (rxUnrF && !(wrStat && busWdata[18])) || (rdRxq && rxEmpty);
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFF_CMD:  busRdata = cmdReg;
      OFF_CMD2: busRdata = cmd2Reg;
      OFF_STAT: begin
        busRdata[31] = busy;
        busRdata[30] = readyF;
        busRdata[25] = rxOvfF;
        busRdata[24] = txUnrF;
        busRdata[23] = rxEmpty;
        busRdata[22] = rxFull;
        busRdata[21] = txEmpty;
        busRdata[20] = txFull;
        busRdata[19] = txOvfF;
        busRdata[18] = rxUnrF;
      end
      OFF_STAT2: begin
        busRdata[16 +: CNT_W] = rxCount;
        busRdata[0 +: CNT_W]  = txCount;
      end
      OFF_RXQ:  busRdata = rxEmpty ? 32'h0 : rxHead;
      default:  busRdata = '0;
    endcase
  end

  assign sclk     = cmdReg[24] ^ sclkTog;
  assign sclkWeak = !busy && cmdReg[25];
  assign csPol    = cmdReg[13];
  assign csActive = cmdReg[11] ? cmdReg[12] : busy;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csN[i] = (csActive && cmd2Reg[19:18] == 2'(i)) ? csPol : !csPol;
  end

  assert_ready_on_finish_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyF) |-> !busy && $past(busy));
  assert_idle_clock_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> sclk == cmdReg[24]);
  assert_edge_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_XFER |-> edgeIdx <= lastIdx);
  assert_cs_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    !csPol |-> $onehot0(~csN));
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int DIV_W  = 8,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [8:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        sclk,
  output logic        sclkWeak,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  csN
);
  dpStrobe_t stb;
  logic [31:0] rxHead;
  logic [CNT_W-1:0] txCount, rxCount;
  logic txEmpty, txFull, rxEmpty, rxFull;

  spi_word_ctrl #(.QDEPTH(QDEPTH), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount),
    .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .stb(stb), .sclk(sclk), .sclkWeak(sclkWeak), .csN(csN));

  spi_word_dp #(.QDEPTH(QDEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .miso(miso),
    .mosi(mosi), .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount),
    .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull));
endmodule

// File: tb/spi_word_master_tb.sv
module spi_word_master_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [8:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic sclk, sclkWeak, mosi, miso;
  logic [3:0] csN;
  logic loopOn = 1'b1, forceLvl = 1'b0;
  int checks = 0, fails = 0;
  logic [31:0] expQ[$];

  assign miso = loopOn ? mosi : forceLvl;
  always #(CLK_PERIOD/2) clk = ~clk;

  spi_word_master u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sclk(sclk), .sclkWeak(sclkWeak),
    .mosi(mosi), .miso(miso), .csN(csN));

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk); busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [8:0] a, output logic [31:0] d);
    busRd = 1'b1; busAddr = a; #1; d = busRdata;
    @(posedge clk); @(negedge clk); busRd = 1'b0;
  endtask

  // driver: start a transfer, time busy, push the word the scoreboard expects
  task automatic runXfer(input logic [31:0] cmd, input int divisor,
                         input logic expectRx, input logic [31:0] expWord,
                         input string tag);
    logic [31:0] s;
    int n, busyCycles;
    n = int'(cmd[4:0]) + 1;
    busWrite(9'h000, cmd | 32'h4000_0000);
    busyCycles = 0;
    busRead(9'h008, s);
    while (s[31] && busyCycles < 1000) begin
      busyCycles++;
      busRead(9'h008, s);
    end
    check(busyCycles == 2*n*(divisor+1)+1, {tag, " busy length"}, busyCycles,
          2*n*(divisor+1)+1);
    check(s[30], {tag, " ready set"}, s, 32'h4000_0000);
    if (expectRx) expQ.push_back(expWord);
  endtask

  // monitor: pop a word from the receive queue and compare with the scoreboard
  task automatic drainOne(input string tag);
    logic [31:0] d, e;
    e = expQ.pop_front();
    busRead(9'h180, d);
    check(d == e, tag, d, e);
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    busRead(9'h008, r);
    check(r == 32'h00A0_0000, "R1 status", r, 32'h00A0_0000);
    check(csN == 4'hF && sclk == 1'b0 && sclkWeak == 1'b0, "R1 pins",
          {26'h0, csN, sclk, sclkWeak}, 32'h3C);

    // R2 R3 R6: 8-bit loopback, leading-edge sampling, engine chip select
    busWrite(9'h004, 32'hC000_0000);
    busWrite(9'h100, 32'h0000_00A5);
    fork
      runXfer(32'h9000_0007, 0, 1'b1, 32'hA5, "R2 8-bit");
      begin
        @(negedge clk); @(negedge clk); #1;
        check(csN == 4'hE, "R6 engine CS during busy", csN, 4'hE);
      end
    join
    check(csN == 4'hF, "R6 engine CS released", csN, 4'hF);

    // R7: write 0 leaves ready, write 1 clears it
    busWrite(9'h008, 32'h0);
    busRead(9'h008, r);
    check(r[30], "R7 write zero keeps ready", r, 32'h4000_0000);
    busWrite(9'h008, 32'h4000_0000);
    busRead(9'h008, r);
    check(!r[30], "R7 write one clears ready", r, 32'h0);

    // R5: idle high, driven
    busWrite(9'h000, 32'h9120_0000);
    check(sclk == 1'b1 && sclkWeak == 1'b0, "R5 driven high idle",
          {sclk, sclkWeak}, 2'b10);
    // R4: trailing-edge sampling, 12 bits
    busWrite(9'h100, 32'h0000_0ABC);
    runXfer(32'h9120_000B, 0, 1'b1, 32'hABC, "R4 12-bit");
    check(sclk == 1'b1, "R5 idle level after transfer", sclk, 1);

    // R14 R3: 32 bits at divisor 2
    busWrite(9'h004, 32'hC000_0002);
    busWrite(9'h100, 32'hDEAD_BEEF);
    runXfer(32'h9000_001F, 2, 1'b1, 32'hDEAD_BEEF, "R14 32-bit div2");
    busWrite(9'h004, 32'hC000_0000);

    // R3: forced-high input, zero data, 5 bits -> right-aligned ones
    loopOn = 1'b0; forceLvl = 1'b1;
    busWrite(9'h100, 32'h0);
    runXfer(32'h9000_0004, 0, 1'b1, 32'h1F, "R3 5-bit align");
    loopOn = 1'b1;

    // R13 R9: receive queue full
    busRead(9'h01C, r);
    check(r == 32'h0004_0000, "R13 status2 levels", r, 32'h0004_0000);
    busRead(9'h008, r);
    check(r[22], "R9 receive full flag", r, 32'h0040_0000);
    busWrite(9'h100, 32'h1);
    runXfer(32'h9000_0000, 0, 1'b0, 32'h0, "R9 overflow xfer");
    busRead(9'h008, r);
    check(r[25], "R9 overflow flag", r, 32'h0200_0000);
    for (int i = 0; i < 4; i++) drainOne("R9 R3 R4 scoreboard word");
    busRead(9'h180, r);
    check(r == 32'h0, "R9 empty read value", r, 32'h0);
    busRead(9'h008, r);
    check(r[18], "R9 underrun read flag", r, 32'h0004_0000);
    busWrite(9'h008, r);
    busRead(9'h008, r);
    check(r == 32'h00A0_0000, "R7 write-back clears all", r, 32'h00A0_0000);

    // R10: start with empty transmit queue
    runXfer(32'h9000_0007, 0, 1'b1, 32'h0, "R10 empty start");
    busRead(9'h008, r);
    check(r[24], "R10 underrun flag", r, 32'h0100_0000);
    drainOne("R10 zeros shifted");

    // R11: receive disabled
    busWrite(9'h004, 32'h4000_0000);
    busWrite(9'h100, 32'h0000_00FF);
    runXfer(32'h9000_0007, 0, 1'b0, 32'h0, "R11 rx off");
    busRead(9'h01C, r);
    check(r == 32'h0, "R11 nothing received", r, 32'h0);
    // R11: transmit disabled
    busWrite(9'h004, 32'h8000_0000);
    busWrite(9'h100, 32'h0000_0055);
    runXfer(32'h9000_0007, 0, 1'b1, 32'h0, "R11 tx off");
    busRead(9'h01C, r);
    check(r == 32'h0001_0001, "R11 tx queue untouched", r, 32'h0001_0001);
    drainOne("R11 zeros with tx off");

    // R8: overflow transmit queue
    for (int i = 0; i < 4; i++) busWrite(9'h100, 32'(i));
    busRead(9'h008, r);
    check(r[19] && r[20], "R8 tx overflow and full", r, 32'h0018_0000);
    busRead(9'h01C, r);
    check(r == 32'h4, "R8 tx level capped", r, 32'h4);

    // R12: start without enable is ignored
    busWrite(9'h000, 32'h5000_0007);
    busRead(9'h008, r);
    check(!r[31], "R12 no busy", r, 32'h0);
    busRead(9'h01C, r);
    check(r == 32'h4, "R12 queue untouched", r, 32'h4);

    // R6: software chip select on line 2
    busWrite(9'h004, 32'h0008_0000);
    busWrite(9'h000, 32'h9000_1800);
    check(csN == 4'hB, "R6 soft active low", csN, 4'hB);
    busWrite(9'h000, 32'h9000_3800);
    check(csN == 4'h4, "R6 soft active high", csN, 4'h4);
    busWrite(9'h000, 32'h9000_0800);
    check(csN == 4'hF, "R6 soft inactive", csN, 4'hF);

    // R5: pulled high idle
    busWrite(9'h000, 32'h9300_0000);
    check(sclk == 1'b1 && sclkWeak == 1'b1, "R5 weak high idle",
          {sclk, sclkWeak}, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule